// File: doc/BRIEF.md
# GPIO Control Register Block

This block is a small 16-bit register peripheral on a synchronous memory-mapped bus. It holds six plain storage registers: control, clock divider, clock control, and the interrupt request, mask and status words. It also holds a power register with a write side effect, a read-only status word, and the GPIO direction and level registers that drive sixteen output lines. The interrupt words are only storage; nothing in the block raises an interrupt from them.

Software sets a pin's direction bit to make it an output. It then writes the level register, through either of its two aliased offsets, to choose the driven value. The output pins always show the level ANDed with the direction. They are refreshed only when one of those two registers is written. The sixteen input lines write their own bits into the level register whenever they change. That update alone leaves the pins as they are. Read data is registered and arrives one clock after the read strobe.

Top module: `gpreg_top`

## Requirements
- R1: Only bus_addr[5:0] selects a register. Every higher address bit is ignored, so an address with arbitrary upper bits reaches the same register as its low six bits alone.
- R2: The control (0x00), clock divider (0x04), clock control (0x10), interrupt request (0x14), interrupt mask (0x18) and interrupt status (0x1C) registers store bus_wdata[15:0] when written and return it when read. The upper write-data bits are dropped.
- R3: A write to the power register (0x0C) stores bus_wdata[15:0]. When bus_wdata[7] is 1, bits 15 and 6 are also stored as 1, which means the value is ORed with 0x8040.
- R4: The status word (0x08) always reads 0x0002, including directly after reset. Writes to it change nothing.
- R5: The direction register sits at 0x20. Offsets 0x24 and 0x28 both read and write the single level register. A write to either stores bus_wdata[15:0] ANDed with the direction value held before the write.
- R6: After a write to the direction or level register, gpio_out equals level AND direction from the first clock edge after the write strobe.
- R7: gpio_out keeps its value in every cycle with no direction or level write, including when gpio_in changes or other registers are written.
- R8: When gpio_in[i] changes, level bit i takes the new pin value at the next clock edge. Software can see this through a read of 0x24 or 0x28.
- R9: A read of any offset other than the eleven listed ones returns 0. A write to such an offset leaves every register and gpio_out unchanged.
- R10: bus_rdata is loaded on the clock edge that samples bus_rd. It holds its value until the next read strobe, even if the register it came from is written in the meantime.
- R11: Reset (rst_n low) clears every stored register, the pin history, bus_rdata and gpio_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 5:0 are decoded |
| bus_wdata | input | BUS_W (32) | Write data; only bits 15:0 are stored |
| bus_rdata | output | 16 | Registered read data |
| gpio_in | input | 16 | Input lines that update level bits when they change |
| gpio_out | output | 16 | Gated output lines, level AND direction |

## Verification
The assertions assume that the strobes, the address and the write data carry known values on every clock edge. They also assume that a read strobe is judged only by the data captured on the edge that samples it. The output-hold property assumes the pins move only through the two GPIO write offsets, with any upper address bits. For this reason the bench changes gpio_in only in cycles with no bus strobe and holds each strobe for exactly one cycle. It also sweeps all 64 offsets, with non-zero upper address bits and upper write-data bits, so that every decode path is exercised inside those assumptions.

// File: rtl/gpreg_pkg.sv
package gpreg_pkg;
  localparam int OFS_W    = 6;
  localparam int REG_W    = 16;
  localparam int N_PLAIN  = 6;
  localparam int PWR_TRIG = 7;

  localparam logic [REG_W-1:0] STAT_VAL  = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE = 16'h8040;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_DIV, SEL_STAT, SEL_PWR, SEL_CLK,
    SEL_IREQ, SEL_IMSK, SEL_ISTS, SEL_DIR, SEL_LVL
  } reg_sel_e;

  // Selector of plain storage slot i.
  function automatic reg_sel_e plain_sel(input int idx);
    case (idx)
      0:       plain_sel = SEL_CTRL;
      1:       plain_sel = SEL_DIV;
      2:       plain_sel = SEL_CLK;
      3:       plain_sel = SEL_IREQ;
      4:       plain_sel = SEL_IMSK;
      default: plain_sel = SEL_ISTS;
    endcase
  endfunction
endpackage

// File: rtl/gpreg_decode.sv
module gpreg_decode
  import gpreg_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output reg_sel_e         sel
);
  always_comb begin
    case (ofs)
      6'h00:        sel = SEL_CTRL;
      6'h04:        sel = SEL_DIV;
      6'h08:        sel = SEL_STAT;
      6'h0C:        sel = SEL_PWR;
      6'h10:        sel = SEL_CLK;
      6'h14:        sel = SEL_IREQ;
      6'h18:        sel = SEL_IMSK;
      6'h1C:        sel = SEL_ISTS;
      6'h20:        sel = SEL_DIR;
      6'h24, 6'h28: sel = SEL_LVL;
      default:      sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpreg_store.sv
module gpreg_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/gpreg_gpio.sv
module gpreg_gpio #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] pins_in,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] pins_out
);
  logic [N-1:0] pin_hist_q, pin_chg;
  logic [N-1:0] lvl_bus, lvl_nxt, dir_nxt, out_nxt;

  always_comb begin
    pin_chg = pins_in ^ pin_hist_q;
    lvl_bus = lvl_we ? (wdata & dir_q) : lvl_q;
    lvl_nxt = (lvl_bus & ~pin_chg) | (pins_in & pin_chg);
    dir_nxt = dir_we ? wdata : dir_q;
    out_nxt = (dir_we || lvl_we) ? (lvl_nxt & dir_nxt) : pins_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist_q <= '0;
      lvl_q      <= '0;
      dir_q      <= '0;
      pins_out   <= '0;
    end else begin
      pin_hist_q <= pins_in;
      lvl_q      <= lvl_nxt;
      dir_q      <= dir_nxt;
      pins_out   <= out_nxt;
    end
  end
endmodule

// File: rtl/gpreg_top.sv
module gpreg_top
  import gpreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  gpio_in,
  output logic [REG_W-1:0]  gpio_out
);
  reg_sel_e         sel;
  logic [REG_W-1:0] wd16, pwr_d, pwr_q, dir_q, lvl_q, rd_val, rdata_nxt;
  logic [REG_W-1:0] plain_q [N_PLAIN];
  logic             unused_hi;

  assign unused_hi = ^{bus_addr[ADDR_W-1:OFS_W], bus_wdata[BUS_W-1:REG_W]};
  assign wd16      = bus_wdata[REG_W-1:0];

  gpreg_decode u_dec (.ofs(bus_addr[OFS_W-1:0]), .sel(sel));

  for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
    gpreg_store #(.W(REG_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .en(bus_wr && (sel == plain_sel(gi))),
      .d(wd16), .q(plain_q[gi])
    );
  end

  always_comb pwr_d = wd16[PWR_TRIG] ? (wd16 | PWR_FORCE) : wd16;

  gpreg_store #(.W(REG_W)) u_pwr (
    .clk(clk), .rst_n(rst_n),
    .en(bus_wr && (sel == SEL_PWR)), .d(pwr_d), .q(pwr_q)
  );

  gpreg_gpio #(.N(REG_W)) u_gpio (
    .clk(clk), .rst_n(rst_n),
    .dir_we(bus_wr && (sel == SEL_DIR)),
    .lvl_we(bus_wr && (sel == SEL_LVL)),
    .wdata(wd16), .pins_in(gpio_in),
    .dir_q(dir_q), .lvl_q(lvl_q), .pins_out(gpio_out)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rd_val = plain_q[0];
      SEL_DIV:  rd_val = plain_q[1];
      SEL_CLK:  rd_val = plain_q[2];
      SEL_IREQ: rd_val = plain_q[3];
      SEL_IMSK: rd_val = plain_q[4];
      SEL_ISTS: rd_val = plain_q[5];
      SEL_STAT: rd_val = STAT_VAL;
      SEL_PWR:  rd_val = pwr_q;
      SEL_DIR:  rd_val = dir_q;
      SEL_LVL:  rd_val = lvl_q;
      default:  rd_val = '0;
    endcase
    rdata_nxt = bus_rd ? rd_val : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_nxt;
  end
endmodule

// File: rtl/gpreg_checker.sv
module gpreg_checker #(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic [15:0]       gpio_out,
  input logic [15:0]       dir_q,
  input logic [15:0]       pwr_q
);
  logic [5:0] ofs;
  logic       gpio_wr, known_ofs;
  assign ofs       = bus_addr[5:0];
  assign gpio_wr   = bus_wr && (ofs == 6'h20 || ofs == 6'h24 || ofs == 6'h28);
  assign known_ofs = (ofs[1:0] == 2'b00) && (ofs <= 6'h28);

  AST_PWR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ofs == 6'h0C && bus_wdata[7]) |=> (pwr_q[15] && pwr_q[6] && pwr_q[7])); // R3

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ofs == 6'h08) |=> (bus_rdata == 16'h0002)); // R4

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_out & ~dir_q) == 16'h0000)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_wr |=> $stable(gpio_out)); // R7

  AST_UNDEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !known_ofs) |=> (bus_rdata == 16'h0000)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

bind gpreg_top gpreg_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .gpio_out(gpio_out), .dir_q(dir_q), .pwr_q(pwr_q)
);

// File: tb/test_gpreg_top.sv
`timescale 1ns/1ps
module test_gpreg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata, gpio_in, gpio_out;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic [15:0] m_ctrl, m_div, m_pwr, m_clk, m_ireq, m_imsk, m_ists, m_dir, m_lvl, m_out;

  always #2 clk = ~clk; // 250 MHz

  gpreg_top i_gpreg_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [5:0] o);
    case (o)
      6'h00: m_read = m_ctrl;
      6'h04: m_read = m_div;
      6'h08: m_read = 16'h0002;
      6'h0C: m_read = m_pwr;
      6'h10: m_read = m_clk;
      6'h14: m_read = m_ireq;
      6'h18: m_read = m_imsk;
      6'h1C: m_read = m_ists;
      6'h20: m_read = m_dir;
      6'h24, 6'h28: m_read = m_lvl;
      default: m_read = 16'h0000;
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] o);
    case (o)
      6'h08: req_of = "R4 status";
      6'h0C: req_of = "R3 power (R1 upper bits)";
      6'h20, 6'h24, 6'h28: req_of = "R5 gpio regs (R1 upper bits)";
      6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C: req_of = "R2 plain (R1 upper bits)";
      default: req_of = "R9 undecoded";
    endcase
  endfunction

  task automatic m_write(input logic [5:0] o, input logic [15:0] w);
    case (o)
      6'h00: m_ctrl = w;
      6'h04: m_div  = w;
      6'h0C: m_pwr  = w[7] ? (w | 16'h8040) : w;
      6'h10: m_clk  = w;
      6'h14: m_ireq = w;
      6'h18: m_imsk = w;
      6'h1C: m_ists = w;
      6'h20: begin m_dir = w; m_out = m_lvl & m_dir; end
      6'h24, 6'h28: begin m_lvl = w & m_dir; m_out = m_lvl & m_dir; end
      default: ;
    endcase
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(a[5:0], d[15:0]);
  endtask

  task automatic do_read(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic read_all(input logic [5:0] hi, input string tag);
    logic [15:0] v;
    for (int o = 0; o < 64; o++) begin
      do_read({hi, 6'(o)}, v);
      check($sformatf("%s %s ofs 0x%02h", tag, req_of(6'(o)), o), v, m_read(6'(o)));
    end
  endtask

  task automatic pins(input logic [15:0] nv);
    logic [15:0] chg;
    @(negedge clk);
    chg = nv ^ gpio_in;
    gpio_in = nv;
    m_lvl = (m_lvl & ~chg) | (nv & chg);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v, held;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; gpio_in = '0;
    {m_ctrl, m_div, m_pwr, m_clk, m_ireq, m_imsk, m_ists, m_dir, m_lvl, m_out} = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 rdata after reset", bus_rdata, 16'h0000);
    check("R11 gpio_out after reset", gpio_out, 16'h0000);
    rst_n = 1'b1;
    read_all(6'h00, "R11 reset");

    // sweep every offset, writing with junk in the upper bits
    for (int r = 0; r < 2; r++) begin
      for (int o = 0; o < 64; o++) begin
        logic [15:0] p;
        p = 16'(16'h5A3C ^ (o * 16'h0421) ^ (r * 16'h00C3));
        do_write({6'(o + 5 + r), 6'(o)}, {16'hBEEF, p});
        check($sformatf("R6/R7 gpio_out after write ofs 0x%02h", o), gpio_out, m_out);
        read_all(6'(o * 3 + r), "sweep");
      end
    end

    // power side effect, bit7 both ways
    do_write(12'h00C, 32'hFFFF_0080);
    do_read(12'h00C, v); check("R3 power bit7 set", v, 16'h80C0);
    do_write(12'h00C, 32'h0000_1201);
    do_read(12'h00C, v); check("R3 power bit7 clear", v, 16'h1201);
    do_write(12'h008, 32'h0000_FFFF);
    do_read(12'h008, v); check("R4 status write ignored", v, 16'h0002);

    // GPIO gating and alias
    do_write(12'h020, 32'h0000_00FF);
    do_write(12'h028, 32'h0000_0FF0);
    check("R6 out after level write", gpio_out, 16'h00F0);
    do_read(12'h024, v); check("R5 alias read 0x24", v, 16'h00F0);
    pins(16'hFFFF);
    check("R7 out held on pin change", gpio_out, 16'h00F0);
    do_read(12'h028, v); check("R8 level follows pins", v, 16'hFFFF);
    do_write(12'h020, 32'h0000_0F0F);
    check("R6 out after direction write", gpio_out, 16'h0F0F);
    pins(16'h0000);
    check("R7 out held on pin fall", gpio_out, 16'h0F0F);
    do_read(12'h024, v); check("R8 level cleared by pins", v, 16'h0000);
    do_write(12'h024, 32'h0000_1234);
    check("R5/R6 masked level write", gpio_out, 16'h0204);
    pins(16'h8001);
    do_read(12'h024, v); check("R8 single pin edges", v, 16'h8205);
    do_write(12'h03C, 32'h0000_FFFF);
    check("R9 undecoded write leaves out", gpio_out, 16'h0204);
    read_all(6'h2A, "post");

    // registered read timing and hold
    do_write(12'h000, 32'h0000_A1A1);
    do_read(12'h000, held);
    check("R10 one-cycle read data", held, 16'hA1A1);
    do_write(12'h000, 32'h0000_5E5E);
    repeat (3) @(negedge clk);
    check("R10 rdata holds without strobe", bus_rdata, 16'hA1A1);
    do_read(12'h000, v); check("R10 new read", v, 16'h5E5E);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule